// File: doc/BRIEF.md
# Circular Mux-Expander Cell Array

This block is a ring of routing cells. Each cell owns a four-slot multiplexer steered by a two-bit select that walks its slots in Gray order. Every slot normally carries its own direct input. A small configuration field per slot can instead feed that slot from the mux output of one of the cell's four closest neighbours: two behind it and two ahead of it on the ring. Because neighbour outputs can feed neighbour inputs, several cells chain into one wider multiplexer without any trip through a global interconnect. A root cell with four leaf cells forms a full 16-to-1 selector.

Neighbour positions wrap modulo the cell count. The first and last cells therefore borrow from each other, and a cascade may straddle the seam of the ring. The array is purely combinational. Configuration and select storage sit outside it. The user must keep the chosen neighbour links free of cycles.

Top module: `mxa_ring`

## Requirements
- R1: A cell's select picks its slot in Gray order: select 00 gives slot 0, 01 gives slot 1, 11 gives slot 2 and 10 gives slot 3. The select is bit 1 then bit 0 of the cell's entry in `sel`.
- R2: A slot whose 3-bit config field is 0 carries that slot's direct input. With every config at 0, each output is the direct input named by its select.
- R3: Config values 1, 2, 3 and 4 feed the slot from the mux output of cell n-2, n-1, n+1 and n+2 respectively.
- R4: While a slot takes a neighbour output, its direct input has no effect on the cell output.
- R5: Config values 5, 6 and 7 behave exactly like 0: the direct input is used.
- R6: Neighbour positions wrap modulo N_CELLS. Cell 0 reaches cells N-2, N-1, 1 and 2, and cell N-1 reaches cells N-3, N-2, 0 and 1.
- R7: One root cell fed by four leaf cells on its four neighbour links forms a 16-to-1 mux. This also holds when the tree crosses the ring seam.
- R8: Each slot of each cell is configured independently of the other slots and cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_in | input | N_CELLS*4*W | Direct inputs; entry [c][s] is slot s of cell c |
| sel | input | N_CELLS*2 | Gray-coded slot select per cell |
| slot_cfg | input | N_CELLS*4*3 | Source field per slot: 0 direct, 1..4 neighbour n-2, n-1, n+1, n+2, 5..7 direct |
| mux_out | output | N_CELLS*W | Mux output of each cell |

## Verification
Direct-only stimulus with random data and selects isolates the Gray slot decode from the neighbour paths. Single-link tests set one neighbour output high and all others low, then swap the polarity. This shows which cell a link actually reaches, both in the interior and at the wrapping ends. It also separates spare config codes from real neighbour codes. The 16-to-1 trees walk every one of the sixteen leaf inputs with one-hot and inverted one-hot data, in the interior and across the seam, while the root's own direct inputs hold the opposite value. Random acyclic mixed configurations are compared on every cycle against a fixed-point behavioural model of the whole ring.

// File: rtl/mxa_pkg.sv
`timescale 1ns/1ps
package mxa_pkg;
  localparam int SLOTS = 4;
  localparam int CFG_W = 3;
  localparam int SEL_W = 2;

  localparam logic [CFG_W-1:0] SRC_DIRECT = 3'd0;
  localparam logic [CFG_W-1:0] SRC_BACK2  = 3'd1;
  localparam logic [CFG_W-1:0] SRC_BACK1  = 3'd2;
  localparam logic [CFG_W-1:0] SRC_FWD1   = 3'd3;
  localparam logic [CFG_W-1:0] SRC_FWD2   = 3'd4;

  // Gray select to slot number: binary b1 = g1, b0 = g1 ^ g0.
  function automatic logic [1:0] gray_slot(input logic [SEL_W-1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction

  // Offset of neighbour link k (0..3) relative to the cell.
  function automatic int link_offset(input int k);
    return (k < 2) ? (k - 2) : (k - 1);
  endfunction

  // Position on a ring of n cells reached from base by offset.
  function automatic int ring_index(input int base, input int offset, input int n);
    return (((base + offset) % n) + n) % n;
  endfunction
endpackage

// File: rtl/mxa_slot_pick.sv
`timescale 1ns/1ps
module mxa_slot_pick
  import mxa_pkg::*;
#(
  parameter int W = 1
) (
  input  logic [CFG_W-1:0]       cfg,
  input  logic [W-1:0]           direct,
  input  logic [SLOTS-1:0][W-1:0] nbr,
  output logic [W-1:0]           slot_val
);
  logic use_nbr;

  always_comb begin
    use_nbr  = 1'b0;
    slot_val = direct;
    case (cfg)
      SRC_BACK2: begin use_nbr = 1'b1; slot_val = nbr[0]; end
      SRC_BACK1: begin use_nbr = 1'b1; slot_val = nbr[1]; end
      SRC_FWD1:  begin use_nbr = 1'b1; slot_val = nbr[2]; end
      SRC_FWD2:  begin use_nbr = 1'b1; slot_val = nbr[3]; end
      default:   ;
    endcase

    // R2 / R4: no neighbour link means the direct input reaches the slot
    p_direct_keep_r2: assert (use_nbr || slot_val == direct)
      else $error("slot lost its direct input");
    // R5: spare codes never open a neighbour link
    p_spare_code_r5: assert (!(cfg > SRC_FWD2) || !use_nbr)
      else $error("spare config code opened a link");
    // R3: a link code forwards the matching neighbour output
    p_nbr_source_r3: assert (!(cfg >= SRC_BACK2 && cfg <= SRC_FWD2) ||
                             slot_val == nbr[2'(cfg - 3'd1)])
      else $error("slot took the wrong neighbour");
  end
endmodule

// File: rtl/mxa_nbr_tap.sv
`timescale 1ns/1ps
module mxa_nbr_tap
  import mxa_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int W       = 1,
  parameter int IDX     = 0
) (
  input  logic [N_CELLS-1:0][W-1:0] ring_out,
  output logic [SLOTS-1:0][W-1:0]   nbr
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_link
    localparam int SRC = ring_index(IDX, link_offset(k), N_CELLS);
    assign nbr[k] = ring_out[SRC];
  end
endmodule

// File: rtl/mxa_cell.sv
`timescale 1ns/1ps
module mxa_cell
  import mxa_pkg::*;
#(
  parameter int W = 1
) (
  input  logic [SLOTS-1:0][W-1:0]     dir,
  input  logic [SEL_W-1:0]            sel,
  input  logic [SLOTS-1:0][CFG_W-1:0] cfg,
  input  logic [SLOTS-1:0][W-1:0]     nbr,
  output logic [W-1:0]                out
);
  logic [SLOTS-1:0][W-1:0] slots;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    mxa_slot_pick #(.W(W)) u_pick (
      .cfg      (cfg[s]),
      .direct   (dir[s]),
      .nbr      (nbr),
      .slot_val (slots[s])
    );
  end

  always_comb begin
    case (sel)
      2'b00:   out = slots[0];
      2'b01:   out = slots[1];
      2'b11:   out = slots[2];
      default: out = slots[3];
    endcase
    // R1: Gray select order reaches the decoded slot
    p_gray_route_r1: assert (out == slots[gray_slot(sel)])
      else $error("Gray select routed the wrong slot");
  end
endmodule

// File: rtl/mxa_ring.sv
`timescale 1ns/1ps
module mxa_ring
  import mxa_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int W       = 1
) (
  input  logic [N_CELLS-1:0][SLOTS-1:0][W-1:0]     dir_in,
  input  logic [N_CELLS-1:0][SEL_W-1:0]            sel,
  input  logic [N_CELLS-1:0][SLOTS-1:0][CFG_W-1:0] slot_cfg,
  output logic [N_CELLS-1:0][W-1:0]                mux_out
);
  logic [N_CELLS-1:0][W-1:0] cell_out;

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    logic [SLOTS-1:0][W-1:0] nbr;

    // R6: links wrap around the ring
    mxa_nbr_tap #(.N_CELLS(N_CELLS), .W(W), .IDX(c)) u_tap (
      .ring_out (cell_out),
      .nbr      (nbr)
    );

    mxa_cell #(.W(W)) u_cell (
      .dir (dir_in[c]),
      .sel (sel[c]),
      .cfg (slot_cfg[c]),
      .nbr (nbr),
      .out (cell_out[c])
    );
  end

  assign mux_out = cell_out;
endmodule

// File: tb/sim_mxa_ring.sv
`timescale 1ns/1ps
module sim_mxa_ring;
  localparam int N = 8;
  localparam int W = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n;

  logic [N-1:0][3:0][W-1:0] dir_in;
  logic [N-1:0][1:0]        sel;
  logic [N-1:0][3:0][2:0]   slot_cfg;
  logic [N-1:0][W-1:0]      mux_out;

  int m_dir[N][4];
  int m_sel[N];
  int m_cfg[N][4];
  int m_out[N];
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  mxa_ring #(.N_CELLS(N), .W(W)) u0 (
    .dir_in(dir_in), .sel(sel), .slot_cfg(slot_cfg), .mux_out(mux_out)
  );

  function automatic int slot_of(input int s);
    case (s) 0: return 0; 1: return 1; 3: return 2; default: return 3; endcase
  endfunction
  function automatic int sel_for(input int slot);
    case (slot) 0: return 0; 1: return 1; 2: return 3; default: return 2; endcase
  endfunction
  function automatic int hop(input int code);
    case (code) 1: return -2; 2: return -1; 3: return 1; default: return 2; endcase
  endfunction
  function automatic int ring(input int c, input int h);
    return ((c + h) % N + N) % N;
  endfunction

  // behavioural fixed-point evaluation of the whole ring
  task automatic model();
    int nxt[N];
    for (int c = 0; c < N; c++) m_out[c] = 0;
    for (int p = 0; p <= N; p++) begin
      for (int c = 0; c < N; c++) begin
        int v[4];
        for (int s = 0; s < 4; s++) begin
          if (m_cfg[c][s] >= 1 && m_cfg[c][s] <= 4)
            v[s] = m_out[ring(c, hop(m_cfg[c][s]))];
          else
            v[s] = m_dir[c][s];
        end
        nxt[c] = v[slot_of(m_sel[c])];
      end
      for (int c = 0; c < N; c++) m_out[c] = nxt[c];
    end
  endtask

  task automatic clear();
    for (int c = 0; c < N; c++) begin
      m_sel[c] = 0;
      for (int s = 0; s < 4; s++) begin m_dir[c][s] = 0; m_cfg[c][s] = 0; end
    end
  endtask

  task automatic settle();
    @(posedge clk);
    for (int c = 0; c < N; c++) begin
      sel[c] = m_sel[c][1:0];
      for (int s = 0; s < 4; s++) begin
        dir_in[c][s]   = m_dir[c][s][W-1:0];
        slot_cfg[c][s] = m_cfg[c][s][2:0];
      end
    end
    @(negedge clk);
  endtask

  task automatic check_one(input string tag, input int c, input int exp);
    tests++;
    if (mux_out[c] !== exp[W-1:0]) begin
      fails++;
      $display("FAIL %s cell %0d: got %0d expected %0d", tag, c, mux_out[c], exp);
    end
  endtask

  task automatic check_model(input string tag);
    model();
    for (int c = 0; c < N; c++) check_one(tag, c, m_out[c]);
  endtask

  // one neighbour output set to val, every other cell output the opposite
  task automatic link_probe(input string tag, input int c, input int code, input int cfgv,
                            input int val);
    int t;
    clear();
    t = ring(c, hop(code));
    for (int k = 0; k < N; k++) m_dir[k][0] = (k == t) ? val : 1 - val;
    m_cfg[c][0] = cfgv;
    settle();
    check_one(tag, c, (cfgv >= 1 && cfgv <= 4) ? val : 1 - val);
    check_model(tag);
  endtask

  task automatic tree(input string tag, input int r);
    int leaf[4];
    for (int k = 0; k < 4; k++) leaf[k] = ring(r, hop(k + 1));
    for (int i = 0; i < 16; i++) begin
      for (int pol = 0; pol < 2; pol++) begin
        clear();
        for (int k = 0; k < 4; k++) begin
          m_cfg[r][k] = k + 1;
          m_sel[leaf[k]] = sel_for(i % 4);
          for (int s = 0; s < 4; s++)
            m_dir[leaf[k]][s] = ((k == i / 4) && (s == i % 4)) ? 1 - pol : pol;
          m_dir[r][k] = pol;              // replaced inputs hold the wrong value
        end
        m_sel[r] = sel_for(i / 4);
        settle();
        check_one(tag, r, 1 - pol);
      end
    end
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear();
    settle();
    repeat (2) @(negedge clk);
    for (int c = 0; c < N; c++) check_one("R2 reset state", c, 0);
    rst_n = 1'b1;

    // R1 explicit Gray order on cell 0
    for (int s = 0; s < 4; s++) begin
      clear();
      m_dir[0][s] = 1;
      for (int g = 0; g < 4; g++) begin
        m_sel[0] = g;
        settle();
        check_one("R1 gray order", 0, (slot_of(g) == s) ? 1 : 0);
      end
    end

    // R2 random direct-only patterns
    for (int it = 0; it < 40; it++) begin
      clear();
      for (int c = 0; c < N; c++) begin
        m_sel[c] = $urandom_range(0, 3);
        for (int s = 0; s < 4; s++) m_dir[c][s] = $urandom_range(0, 1);
      end
      settle();
      check_model("R2 direct");
    end

    // R3 interior links, both polarities
    for (int code = 1; code <= 4; code++)
      for (int v = 0; v < 2; v++) link_probe("R3 link", 3, code, code, v);

    // R6 wrapping at both ends
    for (int code = 1; code <= 4; code++)
      for (int v = 0; v < 2; v++) begin
        link_probe("R6 wrap low", 0, code, code, v);
        link_probe("R6 wrap high", N - 1, code, code, v);
      end

    // R5 spare codes act as direct
    for (int cv = 5; cv <= 7; cv++)
      for (int v = 0; v < 2; v++) link_probe("R5 spare", 4, 3, cv, v);

    // R4 direct input toggled under an active link
    for (int v = 0; v < 2; v++) begin
      clear();
      m_dir[5][0] = v;
      m_cfg[4][2] = 3;
      m_sel[4] = 3;
      for (int d = 0; d < 2; d++) begin
        m_dir[4][2] = d;
        settle();
        check_one("R4 direct ignored", 4, v);
      end
    end

    // R7 16:1 trees: interior and across the seam
    tree("R7 tree interior", 3);
    tree("R7 tree seam", 0);

    // R8 random independent per-slot configs, acyclic: even cells read odd cells
    for (int it = 0; it < 60; it++) begin
      clear();
      for (int c = 0; c < N; c++) begin
        m_sel[c] = $urandom_range(0, 3);
        for (int s = 0; s < 4; s++) begin
          m_dir[c][s] = $urandom_range(0, 1);
          if (c % 2 == 0) begin
            case ($urandom_range(0, 4))
              0: m_cfg[c][s] = 0;
              1: m_cfg[c][s] = 2;
              2: m_cfg[c][s] = 3;
              default: m_cfg[c][s] = $urandom_range(5, 7);
            endcase
          end
        end
      end
      settle();
      check_model("R8 mixed");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule